// File: doc/BRIEF.md
# Accumulator ALU with Magnitude Flags

This block is the arithmetic core of a small accumulator machine. Two operands arrive each cycle: X from the accumulator and Y from the B register. A two-bit operation code asks for an idle cycle, a compare, an addition or a subtraction. Addition and subtraction yield a result register and a one-cycle valid strobe, which tell the accumulator to load the new value. A compare only refreshes the flags.

The flag register holds five status bits. A negative bit and a carry bit come from the adder/subtractor path. Greater, equal and less bits come from a dedicated unsigned magnitude comparator. A two-bit condition select picks one of four conditions from the registered flags, so a branch unit can test a single bit.

All outputs are registered. An operation applied before a rising edge shows on the outputs right after that edge.

Top module: `acc_alu_unit`

## Requirements
- R1: While reset is active, and just after it, `result_o` is 0, `result_vld_o` is 0 and `flags_o` is 0.
- R2: Operation code 2'b10 (add) loads `result_o` with (X + Y) mod 2^16 and sets the carry flag to the carry out of the 16-bit sum.
- R3: Operation code 2'b11 (subtract) loads `result_o` with (X - Y) mod 2^16 and sets the carry flag to the borrow, which is 1 exactly when X < Y as unsigned numbers.
- R4: After add or subtract, the negative flag equals bit 15 of the new result. After compare, the negative flag is bit 15 of (X - Y) mod 2^16 and the carry flag is the borrow of X - Y.
- R5: After any operation other than idle, exactly one of greater, equal and less is set, from an unsigned comparison of X with Y.
- R6: Operation code 2'b01 (compare) updates the flags, keeps `result_vld_o` low and leaves `result_o` unchanged.
- R7: Operation code 2'b00 (idle) leaves `result_o` and `flags_o` unchanged and keeps `result_vld_o` low, whatever X and Y are.
- R8: `flags_o` bit positions are: [4] negative, [3] carry, [2] greater, [1] equal, [0] less.
- R9: `cond_o` shows the registered flag picked by `cond_sel_i`: 2'b00 negative, 2'b01 greater, 2'b10 equal, 2'b11 less. It follows a change of `cond_sel_i` without waiting for a clock edge.
- R10: Outputs change on the first rising edge after the operation is applied. `result_vld_o` is high for exactly the cycles that follow an add or subtract, so back-to-back operations keep it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code: 00 idle, 01 compare, 10 add, 11 subtract |
| x_i | input | 16 | Operand X (accumulator) |
| y_i | input | 16 | Operand Y (B register) |
| cond_sel_i | input | 2 | Selects the flag shown on cond_o |
| result_o | output | 16 | Registered arithmetic result |
| result_vld_o | output | 1 | Accumulator load strobe, one cycle per add/subtract |
| flags_o | output | 5 | Registered flags {negative, carry, greater, equal, less} |
| cond_o | output | 1 | Selected condition flag |

## Verification
Several rules are checked on every cycle by assertions. Compare and idle never raise the strobe or move the result. Idle freezes the flags. Any real operation leaves exactly one magnitude flag set. The negative flag tracks the result's sign bit after arithmetic. The condition output always matches the flag its select names. The exact arithmetic values can only be shown by the bench's scenarios: wrapped sums and carries, borrows near the operand limits, and the sign bit of a compare difference. The same holds for the strobe staying high across back-to-back operations and the full sequence of values after reset.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_CMP  = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } alu_op_e;

    // Packed: neg is the MSB, lt the LSB of the 5-bit flag word.
    typedef struct packed {
        logic neg;
        logic cy;
        logic gt;
        logic eq;
        logic lt;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

    typedef enum logic [1:0] {
        CSEL_NEG = 2'b00,
        CSEL_GT  = 2'b01,
        CSEL_EQ  = 2'b10,
        CSEL_LT  = 2'b11
    } cond_sel_e;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Separate adder and subtractor; a two-way selector picks one of them.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_sub_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int EW = W + 1;

    logic [EW-1:0] sum_ext;
    logic [EW-1:0] dif_ext;
    logic          borrow;

    always_comb begin
        sum_ext = {1'b0, a_i} + {1'b0, b_i};
        dif_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{(EW-1){1'b0}}, 1'b1};
        borrow  = ~dif_ext[W];
    end

    always_comb begin
        if (sel_sub_i) begin
            res_o = dif_ext[W-1:0];
            cy_o  = borrow;
        end else begin
            res_o = sum_ext[W-1:0];
            cy_o  = sum_ext[W];
        end
    end
endmodule

// File: rtl/alu_magcmp.sv
`timescale 1ns/1ps
// Unsigned magnitude comparator built as an MSB-first scan.
module alu_magcmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         gt_o,
    output logic         eq_o,
    output logic         lt_o
);
    // decided[i]: some bit at or above i differs; above_gt[i]: that first difference favours a
    logic [W:0] decided;
    logic [W:0] a_wins;

    assign decided[W] = 1'b0;
    assign a_wins[W]  = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_scan
        logic diff_bit;
        assign diff_bit   = a_i[i] ^ b_i[i];
        assign decided[i] = decided[i+1] | diff_bit;
        assign a_wins[i]  = decided[i+1] ? a_wins[i+1] : (diff_bit & a_i[i]);
    end

    assign eq_o = ~decided[0];
    assign gt_o = decided[0] & a_wins[0];
    assign lt_o = decided[0] & ~a_wins[0];
endmodule

// File: rtl/alu_cond_mux.sv
`timescale 1ns/1ps
module alu_cond_mux
    import alu_pkg::*;
(
    input  alu_flags_t  flags_i,
    input  logic [1:0]  sel_i,
    output logic        cond_o
);
    always_comb begin
        unique case (cond_sel_e'(sel_i))
            CSEL_NEG: cond_o = flags_i.neg;
            CSEL_GT:  cond_o = flags_i.gt;
            CSEL_EQ:  cond_o = flags_i.eq;
            CSEL_LT:  cond_o = flags_i.lt;
            default:  cond_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_alu_unit.sv
`timescale 1ns/1ps
module acc_alu_unit
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op_i,
    input  logic [W-1:0]        x_i,
    input  logic [W-1:0]        y_i,
    input  logic [1:0]          cond_sel_i,
    output logic [W-1:0]        result_o,
    output logic                result_vld_o,
    output logic [FLAG_W-1:0]   flags_o,
    output logic                cond_o
);
    localparam int SIGN_BIT = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
        alu_flags_t   flg;
    } alu_state_t;

    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [W-1:0] as_res;
    logic         as_cy;
    logic         cmp_gt, cmp_eq, cmp_lt;

    assign op = alu_op_e'(op_i);

    // Compare shares the subtract path for its sign and borrow.
    alu_addsub #(.W(W)) u_addsub (
        .a_i       (x_i),
        .b_i       (y_i),
        .sel_sub_i (op != OP_ADD),
        .res_o     (as_res),
        .cy_o      (as_cy)
    );

    alu_magcmp #(.W(W)) u_cmp (
        .a_i  (x_i),
        .b_i  (y_i),
        .gt_o (cmp_gt),
        .eq_o (cmp_eq),
        .lt_o (cmp_lt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        unique case (op)
            OP_IDLE: ;
            OP_CMP: begin
                st_d.flg = '{neg: as_res[SIGN_BIT], cy: as_cy,
                             gt: cmp_gt, eq: cmp_eq, lt: cmp_lt};
            end
            OP_ADD, OP_SUB: begin
                st_d.res = as_res;
                st_d.vld = 1'b1;
                st_d.flg = '{neg: as_res[SIGN_BIT], cy: as_cy,
                             gt: cmp_gt, eq: cmp_eq, lt: cmp_lt};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o     = st_q.res;
    assign result_vld_o = st_q.vld;
    assign flags_o      = st_q.flg;

    alu_cond_mux u_cond (
        .flags_i (st_q.flg),
        .sel_i   (cond_sel_i),
        .cond_o  (cond_o)
    );
endmodule

// File: rtl/alu_chk.sv
`timescale 1ns/1ps
module alu_chk #(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op_i,
    input logic [W-1:0]  x_i,
    input logic [W-1:0]  y_i,
    input logic [1:0]    cond_sel_i,
    input logic [W-1:0]  result_o,
    input logic          result_vld_o,
    input logic [4:0]    flags_o,
    input logic          cond_o
);
    p_cmp_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |=> (!result_vld_o && $stable(result_o)));

    p_idle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00) |=> (!result_vld_o && $stable(result_o) && $stable(flags_o)));

    p_one_magnitude_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b00) |=> ($countones(flags_o[2:0]) == 1));

    p_magnitude_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_o[2:0]));

    p_equal_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b00 && x_i == y_i) |=> flags_o[1]);

    p_sign_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1]) |=> (flags_o[4] == result_o[W-1]));

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1]) |=> result_vld_o);

    p_cond_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel_i == 2'b00) |-> (cond_o == flags_o[4]));
    p_cond_gt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel_i == 2'b01) |-> (cond_o == flags_o[2]));
    p_cond_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel_i == 2'b10) |-> (cond_o == flags_o[1]));
    p_cond_lt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel_i == 2'b11) |-> (cond_o == flags_o[0]));
endmodule

bind acc_alu_unit alu_chk #(.W(W)) u_alu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .x_i          (x_i),
    .y_i          (y_i),
    .cond_sel_i   (cond_sel_i),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .flags_o      (flags_o),
    .cond_o       (cond_o)
);

// File: tb/tb_acc_alu_unit.sv
`timescale 1ns/1ps
module tb_acc_alu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] x_i = '0;
    logic [15:0] y_i = '0;
    logic [1:0]  cond_sel_i = 2'b00;
    logic [15:0] result_o;
    logic        result_vld_o;
    logic [4:0]  flags_o;
    logic        cond_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] exp_res = '0;
    logic [4:0]  exp_flg = '0;

    always #2 clk = ~clk;

    acc_alu_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
        .cond_sel_i(cond_sel_i), .result_o(result_o), .result_vld_o(result_vld_o),
        .flags_o(flags_o), .cond_o(cond_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference computed from the requirements.
    task automatic model(input logic [1:0] op, input logic [15:0] x, input logic [15:0] y);
        logic [16:0] s, d;
        logic n, c;
        s = {1'b0, x} + {1'b0, y};
        d = {1'b0, x} - {1'b0, y};
        if (op == 2'b00) return;
        if (op == 2'b10) begin
            exp_res = s[15:0]; n = s[15]; c = s[16];
        end else begin
            n = d[15]; c = (x < y);
            if (op == 2'b11) exp_res = d[15:0];
        end
        exp_flg = {n, c, x > y, x == y, x < y};
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] x, input logic [15:0] y,
                          input string req);
        @(negedge clk);
        op_i = op; x_i = x; y_i = y;
        @(negedge clk);
        op_i = 2'b00;
        model(op, x, y);
        check(result_o == exp_res, {req, " result"}, 32'(result_o), 32'(exp_res));
        check(flags_o == exp_flg, {req, " flags"}, 32'(flags_o), 32'(exp_flg));
        check(result_vld_o == op[1], {"R10 strobe ", req}, 32'(result_vld_o), 32'(op[1]));
    endtask

    task automatic t_reset;
        #1;
        check(result_o == 16'h0, "R1 result", 32'(result_o), 0);
        check(result_vld_o == 1'b0, "R1 strobe", 32'(result_vld_o), 0);
        check(flags_o == 5'h0, "R1 flags", 32'(flags_o), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(flags_o == 5'h0 && result_o == 16'h0, "R1 after release", 32'(flags_o), 0);
    endtask

    task automatic t_add;
        run_op(2'b10, 16'd1234, 16'd4321, "R2 add plain");
        run_op(2'b10, 16'hFFFF, 16'h0001, "R2 add wrap carry");
        run_op(2'b10, 16'h7FFF, 16'h0001, "R4 add sign");
        run_op(2'b10, 16'h8000, 16'h8000, "R2 add carry zero");
        @(negedge clk);
        check(result_vld_o == 1'b0, "R10 strobe drop", 32'(result_vld_o), 0);
    endtask

    task automatic t_sub;
        run_op(2'b11, 16'd500, 16'd200, "R3 sub no borrow");
        run_op(2'b11, 16'd200, 16'd500, "R3 sub borrow");
        run_op(2'b11, 16'h0000, 16'hFFFF, "R3 sub limit");
        run_op(2'b11, 16'hABCD, 16'hABCD, "R5 sub equal");
    endtask

    task automatic t_cmp;
        logic [15:0] keep;
        keep = result_o;
        run_op(2'b01, 16'h9000, 16'h0010, "R6 cmp greater unsigned");
        check(result_o == keep, "R6 result held", 32'(result_o), 32'(keep));
        run_op(2'b01, 16'h0010, 16'h9000, "R5 cmp less");
        run_op(2'b01, 16'h0033, 16'h0033, "R4 cmp equal");
        check(flags_o == 5'b00010, "R8 equal position", 32'(flags_o), 32'h2);
    endtask

    task automatic t_idle;
        logic [15:0] r; logic [4:0] f;
        run_op(2'b11, 16'd7, 16'd9, "R3 sub before idle");
        r = result_o; f = flags_o;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_i = 2'b00; x_i = 16'(i * 16'h1111); y_i = 16'(16'hF0F0 ^ i);
        end
        @(negedge clk);
        check(result_o == r, "R7 result frozen", 32'(result_o), 32'(r));
        check(flags_o == f, "R7 flags frozen", 32'(flags_o), 32'(f));
        check(result_vld_o == 1'b0, "R7 strobe low", 32'(result_vld_o), 0);
    endtask

    task automatic t_cond;
        run_op(2'b11, 16'd3, 16'd5, "R9 setup less negative");
        for (int s = 0; s < 4; s++) begin
            logic e;
            cond_sel_i = 2'(s);
            #1;
            e = (s == 0) ? exp_flg[4] : (s == 1) ? exp_flg[2] : (s == 2) ? exp_flg[1] : exp_flg[0];
            check(cond_o == e, "R9 select", 32'(cond_o), 32'(e));
        end
        run_op(2'b01, 16'd9, 16'd2, "R9 setup greater");
        cond_sel_i = 2'b01; #1;
        check(cond_o == 1'b1, "R9 greater selected", 32'(cond_o), 1);
        cond_sel_i = 2'b11; #1;
        check(cond_o == 1'b0, "R9 less selected", 32'(cond_o), 0);
    endtask

    task automatic t_b2b;
        @(negedge clk); op_i = 2'b10; x_i = 16'd10; y_i = 16'd20;
        @(negedge clk); op_i = 2'b11; x_i = 16'd100; y_i = 16'd1;
        check(result_vld_o && result_o == 16'd30, "R10 first of pair", 32'(result_o), 30);
        @(negedge clk); op_i = 2'b00;
        check(result_vld_o && result_o == 16'd99, "R10 second of pair", 32'(result_o), 99);
        @(negedge clk);
        check(result_vld_o == 1'b0, "R10 strobe after pair", 32'(result_vld_o), 0);
        exp_res = 16'd99; exp_flg = 5'b00100;
        check(flags_o == exp_flg, "R8 greater position", 32'(flags_o), 32'(exp_flg));
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_idle();
        t_cond();
        t_b2b();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule